// File: doc/BRIEF.md
# Packet and Word Token Rate Limiter

This block holds one transmit port to a programmed rate with a token bucket that tracks debt rather than credit. Every packet that is allowed to start adds two costs to the debt. The first is a fixed per-packet cost. It also accounts for the 24 bytes of line overhead that the word count leaves out: interframe gap, preamble and CRC. The second is a per-word cost multiplied by the packet length, counted in 8-byte words, so each word stands for 64 bits. The debt drains by a fixed refill amount every clock cycle and never goes below zero.

The debt is held in fine units. The per-packet cost and the burst limit are programmed in coarse units, where one coarse unit equals 256 fine units. The word cost is programmed in fine units. A new packet may begin only while the debt, truncated to coarse units, is no greater than the burst limit. A request made while permission is withheld is dropped and has no effect. Programming the word cost to zero gives packets-per-second limiting, and a non-zero word cost gives bits-per-second limiting. Converting rates into register values is left to software.

Top module: `tok_rate_limiter`

## Requirements
- R1: After reset the debt level reads 0 and the permit output is 1, which gives the port full burst credit.
- R2: The permit output is 1 exactly when the debt divided by 256 (rounded down) is less than or equal to the burst limit.
- R3: A request seen at a clock edge while permit is 1 is accepted. At that edge the debt becomes max(debt-16, 0) + packetCost*256 + length*wordCost.
- R4: In a cycle with no accepted request the debt drops by 16 fine units, and it stops at 0 instead of going negative.
- R5: A request seen while permit is 0 is ignored: it adds no charge, and the debt only drains as in R4.
- R6: With the word cost set to 0 (packets-only mode), the packet length has no effect on the charge.
- R7: The debt register never wraps, even when the largest packet cost and the largest length and word cost are charged together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; clears the debt |
| pktCost | input | PCOST_W | Per-packet cost in coarse units (256 fine) |
| wordCost | input | WCOST_W | Cost per 8-byte word in fine units |
| burstLimit | input | LIMIT_W | Highest coarse debt at which a start is still permitted |
| startReq | input | 1 | Request to start a packet this cycle |
| startLen | input | LEN_W | Length of the requested packet in 8-byte words |
| permit | output | 1 | The next packet may start |
| debtLevel | output | DEBT_W | Current debt in fine units (debug view) |

## Verification
The assertions assume that the rate registers stay unchanged in the cycle after an accepted start. They also assume that startReq is 0 or 1 and never unknown from the first clock after reset. The bench meets both assumptions. It changes pktCost, wordCost and burstLimit only while no request is pending, and it drives every input to a known value at time zero. All input changes happen on the falling edge, so each request is sampled at exactly one rising edge.

// File: rtl/rl_pkg.sv
package rl_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic accept;    // charge the per-packet cost this cycle
    logic addWords;  // also charge length * word cost
  } rl_strobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rl_ctrl.sv
module rl_ctrl #(
  parameter int WCOST_W  = 16,
  parameter int LIMIT_W  = 16,
  parameter int COARSE_W = 22
) (
  input  logic                  startReq,
  input  logic [WCOST_W-1:0]    wordCost,
  input  logic [LIMIT_W-1:0]    burstLimit,
  input  logic [COARSE_W-1:0]   debtCoarse,
  output logic                  permit,
  output rl_pkg::rl_strobe_t    strobes
);

  logic [COARSE_W-1:0] limitWide;

  assign limitWide = COARSE_W'(burstLimit);

  // R2: gate on the coarse view of the debt
  assign permit = (debtCoarse <= limitWide);

  // R3/R5: only a permitted request turns into a charge
  always_comb begin
    strobes.accept   = startReq && permit;
    strobes.addWords = startReq && permit && (wordCost != '0);  // R6
  end

endmodule

// File: rtl/rl_datapath.sv
module rl_datapath #(
  parameter int PCOST_W = 16,
  parameter int WCOST_W = 16,
  parameter int LEN_W   = 12,
  parameter int DEBT_W  = 30,
  parameter int SHIFT   = 8,
  parameter int REFILL  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rl_pkg::rl_strobe_t    strobes,
  input  logic [PCOST_W-1:0]    pktCost,
  input  logic [WCOST_W-1:0]    wordCost,
  input  logic [LEN_W-1:0]      startLen,
  output logic [DEBT_W-1:0]     debt,
  output logic [DEBT_W-SHIFT-1:0] debtCoarse
);

  localparam logic [DEBT_W-1:0] REFILL_V = DEBT_W'(REFILL);

  logic [DEBT_W-1:0] drained;
  logic [DEBT_W-1:0] pktCharge;
  logic [DEBT_W-1:0] wordCharge;
  logic [DEBT_W-1:0] charge;
  logic [DEBT_W-1:0] debtNext;

  // R4: saturating drain
  assign drained    = (debt >= REFILL_V) ? (debt - REFILL_V) : '0;

  // R3: coarse packet cost scaled up, fine word cost times length
  assign pktCharge  = DEBT_W'({pktCost, {SHIFT{1'b0}}});
  assign wordCharge = strobes.addWords ? (DEBT_W'(startLen) * DEBT_W'(wordCost)) : '0;
  assign charge     = pktCharge + wordCharge;

  assign debtNext   = drained + (strobes.accept ? charge : '0);

  always_ff @(posedge clk) begin
    if (!rstN) debt <= '0;           // R1
    else       debt <= debtNext;
  end

  assign debtCoarse = debt[DEBT_W-1:SHIFT];

  // R7: an accepted charge never wraps the register
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> (debt >= $past(charge)))
    else $error("debt wrapped after charge");

endmodule

// File: rtl/tok_rate_limiter.sv
module tok_rate_limiter #(
  parameter int PCOST_W = 16,
  parameter int WCOST_W = 16,
  parameter int LIMIT_W = 16,
  parameter int LEN_W   = 12,
  parameter int SHIFT   = 8,
  parameter int REFILL  = 16,
  localparam int DEBT_W = rl_pkg::maxOf3(LIMIT_W + SHIFT, PCOST_W + SHIFT,
                                         LEN_W + WCOST_W) + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PCOST_W-1:0] pktCost,
  input  logic [WCOST_W-1:0] wordCost,
  input  logic [LIMIT_W-1:0] burstLimit,
  input  logic               startReq,
  input  logic [LEN_W-1:0]   startLen,
  output logic               permit,
  output logic [DEBT_W-1:0]  debtLevel
);

  localparam int COARSE_W = DEBT_W - SHIFT;

  rl_pkg::rl_strobe_t  strobes;
  logic [COARSE_W-1:0] debtCoarse;

  rl_ctrl #(
    .WCOST_W(WCOST_W), .LIMIT_W(LIMIT_W), .COARSE_W(COARSE_W)
  ) u_ctrl (
    .startReq(startReq), .wordCost(wordCost), .burstLimit(burstLimit),
    .debtCoarse(debtCoarse), .permit(permit), .strobes(strobes)
  );

  rl_datapath #(
    .PCOST_W(PCOST_W), .WCOST_W(WCOST_W), .LEN_W(LEN_W),
    .DEBT_W(DEBT_W), .SHIFT(SHIFT), .REFILL(REFILL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pktCost(pktCost),
    .wordCost(wordCost), .startLen(startLen), .debt(debtLevel),
    .debtCoarse(debtCoarse)
  );

  localparam logic [DEBT_W-1:0] REFILL_V = DEBT_W'(REFILL);

  // R4: idle drain by the refill amount
  p_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!(startReq && permit) && debtLevel >= REFILL_V)
      |=> (debtLevel == $past(debtLevel) - REFILL_V))
    else $error("drain step wrong");

  // R4: saturation at zero
  p_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!(startReq && permit) && debtLevel < REFILL_V) |=> (debtLevel == '0))
    else $error("drain did not stop at zero");

  // R5: a blocked request only lowers the debt
  p_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !permit) |=> (debtLevel < $past(debtLevel)))
    else $error("blocked request charged");

  // R6: packets-only charge ignores the length
  p_words_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && permit && wordCost == '0 && debtLevel >= REFILL_V)
      |=> (debtLevel == $past(debtLevel) - REFILL_V
                        + DEBT_W'({$past(pktCost), {SHIFT{1'b0}}})))
    else $error("length charged with zero word cost");

endmodule

// File: tb/sim_tok_rate_limiter.sv
module sim_tok_rate_limiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pktCost = '0;
  logic [15:0] wordCost = '0;
  logic [15:0] burstLimit = '0;
  logic        startReq = 1'b0;
  logic [11:0] startLen = '0;
  logic        permit;
  logic [29:0] debtLevel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  tok_rate_limiter u0 (
    .clk(clk), .rstN(rstN), .pktCost(pktCost), .wordCost(wordCost),
    .burstLimit(burstLimit), .startReq(startReq), .startLen(startLen),
    .permit(permit), .debtLevel(debtLevel)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; holds the request across one rising edge
  task automatic step(input bit req, input int len);
    startReq = req;
    startLen = 12'(len);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    doReset();
    check("R1 debt", debtLevel, 0);
    check("R1 permit", permit, 1);
  endtask

  task automatic t_charge();
    pktCost = 16'd2; wordCost = 16'd10; burstLimit = 16'd3;
    step(1, 5);
    check("R3 charge", debtLevel, 562);
    check("R2 permit at coarse 2", permit, 1);
    idle(1);
    check("R4 drain", debtLevel, 546);
    step(1, 0);
    check("R3 second charge", debtLevel, 1042);
    check("R2 blocked at coarse 4", permit, 0);
  endtask

  task automatic t_reject();
    step(1, 7);
    check("R5 ignored request", debtLevel, 1026);
    check("R2 still blocked", permit, 0);
    idle(1);
    check("R4 drain", debtLevel, 1010);
    check("R2 reopens at coarse 3", permit, 1);
  endtask

  task automatic t_floor();
    idle(70);
    check("R4 floor at zero", debtLevel, 0);
  endtask

  task automatic t_pktOnly();
    wordCost = 16'd0;
    step(1, 4095);
    check("R6 length ignored", debtLevel, 512);
    idle(40);
    check("R4 floor", debtLevel, 0);
  endtask

  task automatic t_burst();
    // 256 per accept, minus 16 drain; sixth request blocked
    pktCost = 16'd1; wordCost = 16'd0; burstLimit = 16'd3;
    for (int i = 0; i < 6; i++) step(1, 0);
    check("R5 burst cut off", debtLevel, 1200);
    check("R2 blocked after burst", permit, 0);
    idle(80);
  endtask

  task automatic t_large();
    longint exp;
    pktCost = 16'hFFFF; wordCost = 16'hFFFF; burstLimit = 16'd3;
    exp = 64'hFFFF * 256 + 64'hFFF * 64'hFFFF;
    step(1, 4095);
    check("R7 largest charge", debtLevel, exp);
    check("R2 blocked", permit, 0);
    doReset();
    check("R1 reset clears", debtLevel, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_charge();
    t_reject();
    t_floor();
    t_pktOnly();
    t_burst();
    t_large();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule